// File: doc/BRIEF.md
# Programmable Carrier Frequency Generator

This block produces the modulation carrier for an infrared-style remote output. It runs from the system clock and advances only when an instruction-rate enable pulse is present, which arrives once every four system clocks. The divide ratio is m·2^n ticks, with m equal to 2 or 3 and n from 0 to 3, so the available ratios are 2, 3, 4, 6, 8, 12, 16 and 24. The high time is either half or one third of the period. All configuration inputs are static straps.

The output pin shares a one-bit port latch. In carrier mode, writing 0 to the latch starts the carrier and writing 1 holds the pin low. In level mode, the pin simply shows the latch value. A one-cycle period strobe is provided for test. It marks the tick that completes each carrier period.

Top module: `carrier_gen`

## Requirements
- R1: The carrier period is R ticks, where R = m·2^n, m = 3 when `cfg_mul3`=1 (else 2) and n = `cfg_exp`. `period_strobe` is 1 only during the cycle that carries the tick which completes a period. That tick is phase R-1, counted from phase 0.
- R2: For ratios 2, 4, 8 and 16 the pin is high for phases 0 to R/2-1 and low for phases R/2 to R-1.
- R3: For ratio 3 the pin is high for phase 0 only and low for phases 1 and 2, whatever the value of `cfg_third`.
- R4: For ratios 6, 12 and 24 the high time is R/3 phases when `cfg_third`=1 and R/2 phases when `cfg_third`=0. The high phases always come first.
- R5: `cfg_third`=1 with `cfg_mul3`=0 has no effect, and the waveform is the 1/2-duty one of R2.
- R6: In carrier mode (`mode_carrier`=1) with the latch at 1, the pin is low and `period_strobe` stays 0, even while ticks arrive.
- R7: In level mode (`mode_carrier`=0) the pin equals the latch value and `period_strobe` stays 0.
- R8: After reset the latch is 1. The pin is therefore low in carrier mode and high in level mode.
- R9: A latch write (`latch_we`=1) loads `latch_d` at the clock edge. Writing 0 in carrier mode restarts the divider at phase 0, so the pin is high from the next cycle for a full high time.
- R10: The phase advances only on cycles with `tick`=1. Between ticks the pin holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Instruction-rate clock enable |
| mode_carrier | input | 1 | 1 = carrier output, 0 = level output |
| cfg_mul3 | input | 1 | Multiplier select: 1 gives m=3, 0 gives m=2 |
| cfg_exp | input | 2 | Exponent n of the divide ratio |
| cfg_third | input | 1 | Requests 1/3 duty where the ratio allows it |
| latch_we | input | 1 | Port latch write strobe |
| latch_d | input | 1 | Port latch write data |
| pin_out | output | 1 | Pin value |
| period_strobe | output | 1 | Period-completion strobe for test |

## Verification
The assertions check several properties on every cycle:
- the pin is held low while the carrier is disabled;
- the pin follows the latch in level mode;
- the latch sits at 1 right after reset;
- the pin goes high in the cycle after the carrier is enabled;
- the strobe appears only on a tick of a running carrier, and only while the pin is low.

The exact waveform can only be shown by the bench. That covers the period length, the high time for each ratio and duty pairing, the forced 1/3 duty at ratio 3, the ignored 1/3 request at power-of-two ratios, and the restart after a disable in mid-period. The bench sweeps every configuration over two periods and compares the result with arithmetic from the requirements.

// File: rtl/carrier_pkg.sv
`timescale 1ns/1ps
package carrier_pkg;
    localparam int EXP_W     = 2;
    localparam int MAX_EXP   = (1 << EXP_W) - 1;
    localparam int MAX_RATIO = 3 << MAX_EXP;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef logic [CNT_W-1:0] phase_t;

    typedef struct packed {
        logic             mul3;
        logic [EXP_W-1:0] expn;
        logic             third;
    } carrier_cfg_t;

    // Period length in ticks: m * 2^n
    function automatic phase_t ratio_of(carrier_cfg_t c);
        phase_t base;
        base = c.mul3 ? phase_t'(3) : phase_t'(2);
        return phase_t'(base << c.expn);
    endfunction

    // One-third duty applies only with m=3; ratio 3 cannot be halved evenly
    function automatic logic third_active(carrier_cfg_t c);
        return c.mul3 && (c.third || (c.expn == '0));
    endfunction

    function automatic phase_t high_len_of(carrier_cfg_t c);
        phase_t r;
        r = ratio_of(c);
        return third_active(c) ? phase_t'(r / 3) : phase_t'(r >> 1);
    endfunction
endpackage

// File: rtl/carrier_latch.sv
`timescale 1ns/1ps
module carrier_latch (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b1;
        else if (we) q <= d;
    end
endmodule

// File: rtl/carrier_divider.sv
`timescale 1ns/1ps
module carrier_divider
    import carrier_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  phase_t ratio,
    output phase_t phase,
    output logic   wrap
);
    logic at_end;

    always_comb begin
        at_end = (phase >= ratio - phase_t'(1));
        wrap   = run && tick && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)  phase <= '0;
        else if (tick)    phase <= at_end ? '0 : phase + phase_t'(1);
    end
endmodule

// File: rtl/carrier_shaper.sv
`timescale 1ns/1ps
module carrier_shaper
    import carrier_pkg::*;
(
    input  logic   mode_carrier,
    input  logic   latch_q,
    input  logic   run,
    input  phase_t phase,
    input  phase_t high_len,
    output logic   pin
);
    always_comb begin
        if (mode_carrier) pin = run && (phase < high_len);
        else              pin = latch_q;
    end
endmodule

// File: rtl/carrier_gen.sv
`timescale 1ns/1ps
module carrier_gen
    import carrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             mode_carrier,
    input  logic             cfg_mul3,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic             cfg_third,
    input  logic             latch_we,
    input  logic             latch_d,
    output logic             pin_out,
    output logic             period_strobe
);
    carrier_cfg_t cfg;
    phase_t       ratio, high_len, phase;
    logic         latch_q, run;

    always_comb begin
        cfg      = '{mul3: cfg_mul3, expn: cfg_exp, third: cfg_third};
        ratio    = ratio_of(cfg);
        high_len = high_len_of(cfg);
        run      = mode_carrier && !latch_q;
    end

    carrier_latch u_latch (
        .clk(clk), .rst(rst), .we(latch_we), .d(latch_d), .q(latch_q)
    );

    carrier_divider u_div (
        .clk(clk), .rst(rst), .run(run), .tick(tick),
        .ratio(ratio), .phase(phase), .wrap(period_strobe)
    );

    carrier_shaper u_shape (
        .mode_carrier(mode_carrier), .latch_q(latch_q), .run(run),
        .phase(phase), .high_len(high_len), .pin(pin_out)
    );
endmodule

// File: rtl/carrier_gen_chk.sv
`timescale 1ns/1ps
module carrier_gen_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic mode_carrier,
    input logic latch_q,
    input logic pin_out,
    input logic period_strobe
);
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
        (mode_carrier && latch_q) |-> (!pin_out && !period_strobe));

    a_r7_level_follow: assert property (@(posedge clk) disable iff (rst)
        !mode_carrier |-> (pin_out == latch_q && !period_strobe));

    a_r8_reset_latch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> latch_q);

    a_r9_restart_high: assert property (@(posedge clk) disable iff (rst)
        ($fell(latch_q) && mode_carrier && $past(mode_carrier)) |-> pin_out);

    a_r10_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
        period_strobe |-> (tick && mode_carrier && !latch_q));

    a_r1_strobe_low_phase: assert property (@(posedge clk) disable iff (rst)
        period_strobe |-> !pin_out);
endmodule

bind carrier_gen carrier_gen_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode_carrier(mode_carrier),
    .latch_q(latch_q), .pin_out(pin_out), .period_strobe(period_strobe)
);

// File: tb/carrier_gen_bench.sv
`timescale 1ns/1ps
module carrier_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       mode_carrier = 1'b1;
    logic       cfg_mul3 = 1'b0;
    logic [1:0] cfg_exp = 2'd0;
    logic       cfg_third = 1'b0;
    logic       latch_we = 1'b0;
    logic       latch_d = 1'b1;
    logic       pin_out, period_strobe;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    carrier_gen u_carrier_gen (
        .clk(clk), .rst(rst), .tick(tick), .mode_carrier(mode_carrier),
        .cfg_mul3(cfg_mul3), .cfg_exp(cfg_exp), .cfg_third(cfg_third),
        .latch_we(latch_we), .latch_d(latch_d),
        .pin_out(pin_out), .period_strobe(period_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string duty_tag(input bit m3, input int e, input bit th);
        if (!m3) return th ? "R5" : "R2";
        if (e == 0) return "R3";
        return "R4";
    endfunction

    // Write the port latch: value lands at the next edge, returns at a negedge
    task automatic write_latch(input bit v);
        latch_we = 1'b1; latch_d = v;
        @(negedge clk);
        latch_we = 1'b0;
    endtask

    // Run nticks ticks from phase 0, one tick every fourth cycle
    task automatic run_phases(input int nticks, input int r, input int h, input string tag);
        for (int t = 0; t < nticks * 4; t++) begin
            int k;
            tick = (t % 4 == 3);
            k = (t / 4) % r;
            #1;
            check(pin_out == (k < h), tick ? tag : "R10", "pin", pin_out, int'(k < h));
            check(period_strobe == (tick && k == r - 1), "R1", "strobe",
                  period_strobe, int'(tick && k == r - 1));
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic sweep_cfg(input bit m3, input int e, input bit th);
        int r, h;
        r = (m3 ? 3 : 2) << e;
        h = (m3 && (th || e == 0)) ? r / 3 : r / 2;
        cfg_mul3 = m3; cfg_exp = 2'(e); cfg_third = th;
        write_latch(1'b1);
        write_latch(1'b0);
        run_phases(2 * r, r, h, duty_tag(m3, e, th));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(pin_out == 1'b0, "R8", "carrier-mode pin after reset", pin_out, 0);
        mode_carrier = 1'b0;
        #1;
        check(pin_out == 1'b1, "R8", "level-mode pin after reset", pin_out, 1);

        // R7: level mode follows latch, no strobe even with ticks
        @(negedge clk);
        write_latch(1'b0);
        for (int i = 0; i < 12; i++) begin
            tick = 1'b1; #1;
            check(pin_out == 1'b0, "R7", "level pin", pin_out, 0);
            check(period_strobe == 1'b0, "R7", "level strobe", period_strobe, 0);
            @(negedge clk);
        end
        tick = 1'b0;
        write_latch(1'b1);
        #1;
        check(pin_out == 1'b1, "R7", "level pin", pin_out, 1);

        // R6: carrier mode disabled by latch 1 under ticks
        mode_carrier = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            tick = 1'b1; #1;
            check(pin_out == 1'b0, "R6", "disabled pin", pin_out, 0);
            check(period_strobe == 1'b0, "R6", "disabled strobe", period_strobe, 0);
            @(negedge clk);
        end
        tick = 1'b0;

        // R1..R5: every configuration over two periods
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 4; e++)
                for (int th = 0; th < 2; th++)
                    sweep_cfg(m[0], e, th[0]);

        // R9: disable in mid-period, then re-enable restarts with a full high time
        cfg_mul3 = 1'b1; cfg_exp = 2'd3; cfg_third = 1'b0;
        write_latch(1'b1);
        write_latch(1'b0);
        run_phases(17, 24, 12, "R4");
        write_latch(1'b1);
        #1;
        check(pin_out == 1'b0, "R6", "pin after disable", pin_out, 0);
        @(negedge clk);
        write_latch(1'b0);
        run_phases(24, 24, 12, "R9");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule